// File: doc/BRIEF.md
# Multiply and Multiply-Accumulate Unit

This block is the multiplier of a small 16-bit CPU core. It takes operand values that the core reads from its register file, runs one of five arithmetic operations over a fixed number of clock cycles, and returns the values to write back. Those are a 16-bit word for the AX pair and a 16-bit word for the BC pair, each with its own write strobe. The block keeps a 32-bit accumulator and the two status flags that the accumulate operations update: carry (CY) and auxiliary carry (AC).

The supported operations are an 8x8 unsigned multiply of A and X, unsigned and signed 16x16 multiplies of AX and BC, and unsigned and signed multiply-accumulate of AX and BC into the accumulator. The accumulate forms set the flags in an unusual way. In signed mode CY reports that the accumulator's sign bit changed and AC takes the new sign. In unsigned mode CY reports a wrap past 2^32 and AC is cleared. A load port lets software set the accumulator, for example to clear it before a run of accumulates.

The core raises `start` for one cycle with an operation code and the operands. `busy` then stays high for the operation's latency. The results, write strobes and `done` appear together in the cycle after `busy` falls.

Top module: `mac16_unit`

## Requirements
- R1: After reset `busy`, `done`, both write strobes, `axOut`, `bcOut`, `accOut`, `cyOut` and `acOut` are all zero.
- R2: Operation code 0 (8x8 unsigned) writes the product `aIn*xIn` to `axOut` with `axWr` high and `bcWr` low, with a latency of 1 cycle.
- R3: Operation code 1 (16x16 unsigned) forms `axIn*bcIn`, puts the high half on `bcOut` and the low half on `axOut`, raises both strobes, and has a latency of 2 cycles.
- R4: Operation code 2 (16x16 signed) treats `axIn` and `bcIn` as two's complement and returns the 32-bit signed product split as in R3, with a latency of 2 cycles.
- R5: Operation code 4 (signed accumulate) adds the signed product of `axIn` and `bcIn` to the accumulator modulo 2^32, with a latency of 3 cycles. CY is set to (new bit 31 XOR old bit 31) and AC to new bit 31.
- R6: Operation code 3 (unsigned accumulate) adds the unsigned product to the accumulator modulo 2^32, with a latency of 3 cycles. CY is set when the new value is below the old one, and AC is cleared.
- R7: The multiply-only codes (0 to 2) leave CY, AC and the accumulator unchanged. The accumulate codes (3, 4) raise neither `axWr` nor `bcWr`, but do raise `done`.
- R8: `busy` is high for exactly the operation's latency after the accepting clock edge. A `start` seen while `busy` is high is ignored.
- R9: With `busy` low, `accLoad` writes `accLoadVal` to the accumulator at the next edge, and a `start` in that same cycle is ignored. With `busy` high, `accLoad` has no effect.
- R10: `start` with an operation code of 5, 6 or 7 is ignored: `busy` stays low and no result or strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the operation given by opSel |
| opSel | input | 3 | Operation code (0 to 4 valid) |
| aIn | input | 8 | A register value |
| xIn | input | 8 | X register value |
| axIn | input | 16 | AX register-pair value |
| bcIn | input | 16 | BC register-pair value |
| accLoad | input | 1 | Write accLoadVal into the accumulator |
| accLoadVal | input | 32 | Accumulator load value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| axWr | output | 1 | Write axOut to AX (with done) |
| axOut | output | 16 | AX write-back value |
| bcWr | output | 1 | Write bcOut to BC (with done) |
| bcOut | output | 16 | BC write-back value |
| accOut | output | 32 | Accumulator contents |
| cyOut | output | 1 | Carry flag |
| acOut | output | 1 | Auxiliary carry flag |

## Verification
On every cycle, the embedded assertions check these rules. The flags and accumulator hold across multiply-only commits and idle cycles. AC is clear after an unsigned accumulate and matches the sign bit after a signed one. Every write strobe comes with `done`, and a busy run never exceeds the longest latency. The arithmetic values, the split of products over BC and AX, and the exact latencies per operation can only be shown by the directed scenarios. So can sign-crossing and wrapping accumulates, and requests ignored while busy, during a load, or with a bad code.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
  typedef enum logic [2:0] {
    OP_MUL8U  = 3'd0,
    OP_MUL16U = 3'd1,
    OP_MUL16S = 3'd2,
    OP_MAC_U  = 3'd3,
    OP_MAC_S  = 3'd4
  } macOp_e;

  typedef struct packed {
    logic capture;   // latch operands and operation
    logic commit;    // final cycle: update results and flags
    logic accWrite;  // load accumulator from the port
  } macCtrl_t;
endpackage

// File: rtl/mac16_ctrl.sv
module mac16_ctrl
  import mac16_pkg::*;
#(
  parameter int LAT_MUL8  = 1,
  parameter int LAT_MUL16 = 2,
  parameter int LAT_MAC   = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic [2:0] opSel,
  input  logic     accLoad,
  output macCtrl_t ctl,
  output logic     busy
);
  localparam int CNT_W = $clog2(LAT_MAC + 1);

  logic             busyR;
  logic [CNT_W-1:0] cntR;
  logic             validOp;
  logic [CNT_W-1:0] latm1;

  always_comb begin
    validOp = (opSel <= 3'd4);
    unique case (opSel)
      3'd0:          latm1 = CNT_W'(LAT_MUL8 - 1);
      3'd1, 3'd2:    latm1 = CNT_W'(LAT_MUL16 - 1);
      default:       latm1 = CNT_W'(LAT_MAC - 1);
    endcase
  end

  always_comb begin
    ctl.capture  = start && !busyR && !accLoad && validOp;
    ctl.commit   = busyR && (cntR == '0);
    ctl.accWrite = accLoad && !busyR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR <= 1'b0;
      cntR  <= '0;
    end else if (ctl.capture) begin
      busyR <= 1'b1;
      cntR  <= latm1;
    end else if (ctl.commit) begin
      busyR <= 1'b0;
    end else if (busyR) begin
      cntR  <= cntR - 1'b1;
    end
  end

  assign busy = busyR;

  // Busy-run length watcher for the latency bound.
  logic [CNT_W:0] runLen;
  always_ff @(posedge clk) begin
    if (!rstN)      runLen <= '0;
    else if (busyR) runLen <= runLen + 1'b1;
    else            runLen <= '0;
  end

  assert_busy_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    busyR |-> (runLen < (CNT_W+1)'(LAT_MAC)));

  assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyR) |-> $past(start));

  assert_load_blocks_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busyR && accLoad) |=> !busyR);

  assert_bad_op_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busyR && opSel > 3'd4) |=> !busyR);
endmodule

// File: rtl/mac16_datapath.sv
module mac16_datapath
  import mac16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  macCtrl_t              ctl,
  input  logic [2:0]            opSel,
  input  logic [DATA_W/2-1:0]   aIn,
  input  logic [DATA_W/2-1:0]   xIn,
  input  logic [DATA_W-1:0]     axIn,
  input  logic [DATA_W-1:0]     bcIn,
  input  logic [2*DATA_W-1:0]   accLoadVal,
  output logic                  done,
  output logic                  axWr,
  output logic [DATA_W-1:0]     axOut,
  output logic                  bcWr,
  output logic [DATA_W-1:0]     bcOut,
  output logic [2*DATA_W-1:0]   accOut,
  output logic                  cyOut,
  output logic                  acOut
);
  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = 2 * DATA_W;

  logic [2:0]        opR;
  logic [HALF_W-1:0] aR, xR;
  logic [DATA_W-1:0] axR, bcR;
  logic [ACC_W-1:0]  accR;
  logic              cyR, acR;

  logic [DATA_W-1:0] prod8;
  logic [ACC_W-1:0]  prodU, prodS, accNext;
  logic              isAcc, isSigned;

  always_comb begin
    prod8    = DATA_W'(aR) * DATA_W'(xR);
    prodU    = ACC_W'(axR) * ACC_W'(bcR);
    prodS    = {{DATA_W{axR[DATA_W-1]}}, axR} * {{DATA_W{bcR[DATA_W-1]}}, bcR};
    isAcc    = (opR == OP_MAC_U) || (opR == OP_MAC_S);
    isSigned = (opR == OP_MAC_S);
    accNext  = accR + (isSigned ? prodS : prodU);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR <= '0; aR <= '0; xR <= '0; axR <= '0; bcR <= '0;
    end else if (ctl.capture) begin
      opR <= opSel; aR <= aIn; xR <= xIn; axR <= axIn; bcR <= bcIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accR <= '0; cyR <= 1'b0; acR <= 1'b0;
    end else if (ctl.accWrite) begin
      accR <= accLoadVal;
    end else if (ctl.commit && isAcc) begin
      accR <= accNext;
      if (isSigned) begin
        cyR <= accNext[ACC_W-1] ^ accR[ACC_W-1];
        acR <= accNext[ACC_W-1];
      end else begin
        cyR <= (accNext < accR);
        acR <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; axWr <= 1'b0; bcWr <= 1'b0;
      axOut <= '0; bcOut <= '0;
    end else begin
      done <= ctl.commit;
      axWr <= 1'b0;
      bcWr <= 1'b0;
      if (ctl.commit) begin
        unique case (opR)
          OP_MUL8U: begin
            axOut <= prod8;
            axWr  <= 1'b1;
          end
          OP_MUL16U: begin
            {bcOut, axOut} <= prodU;
            axWr <= 1'b1; bcWr <= 1'b1;
          end
          OP_MUL16S: begin
            {bcOut, axOut} <= prodS;
            axWr <= 1'b1; bcWr <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign accOut = accR;
  assign cyOut  = cyR;
  assign acOut  = acR;

  assert_plain_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && !isAcc) |=> (cyR == $past(cyR) && acR == $past(acR) && accR == $past(accR)));

  assert_unsigned_ac_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && opR == OP_MAC_U) |=> !acR);

  assert_signed_ac_sign_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && opR == OP_MAC_S) |=> (acR == accR[ACC_W-1]));

  assert_idle_acc_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.commit && !ctl.accWrite) |=> $stable(accR));

  assert_strobe_with_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    (axWr || bcWr) |-> done);
endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
  import mac16_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int LAT_MUL8  = 1,
  parameter int LAT_MUL16 = 2,
  parameter int LAT_MAC   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          opSel,
  input  logic [DATA_W/2-1:0] aIn,
  input  logic [DATA_W/2-1:0] xIn,
  input  logic [DATA_W-1:0]   axIn,
  input  logic [DATA_W-1:0]   bcIn,
  input  logic                accLoad,
  input  logic [2*DATA_W-1:0] accLoadVal,
  output logic                busy,
  output logic                done,
  output logic                axWr,
  output logic [DATA_W-1:0]   axOut,
  output logic                bcWr,
  output logic [DATA_W-1:0]   bcOut,
  output logic [2*DATA_W-1:0] accOut,
  output logic                cyOut,
  output logic                acOut
);
  macCtrl_t ctl;

  mac16_ctrl #(
    .LAT_MUL8(LAT_MUL8), .LAT_MUL16(LAT_MUL16), .LAT_MAC(LAT_MAC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .accLoad(accLoad), .ctl(ctl), .busy(busy)
  );

  mac16_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opSel(opSel),
    .aIn(aIn), .xIn(xIn), .axIn(axIn), .bcIn(bcIn), .accLoadVal(accLoadVal),
    .done(done), .axWr(axWr), .axOut(axOut), .bcWr(bcWr), .bcOut(bcOut),
    .accOut(accOut), .cyOut(cyOut), .acOut(acOut)
  );
endmodule

// File: tb/mac16_unit_tb.sv
`timescale 1ns/1ps
module mac16_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [7:0]  aIn = '0, xIn = '0;
  logic [15:0] axIn = '0, bcIn = '0;
  logic        accLoad = 1'b0;
  logic [31:0] accLoadVal = '0;
  logic        busy, done, axWr, bcWr, cyOut, acOut;
  logic [15:0] axOut, bcOut;
  logic [31:0] accOut;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] mAcc = '0;
  logic        mCy = 1'b0, mAc = 1'b0;

  always #2.5 clk = ~clk;

  mac16_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .aIn(aIn), .xIn(xIn), .axIn(axIn), .bcIn(bcIn),
    .accLoad(accLoad), .accLoadVal(accLoadVal),
    .busy(busy), .done(done), .axWr(axWr), .axOut(axOut),
    .bcWr(bcWr), .bcOut(bcOut), .accOut(accOut), .cyOut(cyOut), .acOut(acOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one operation and count busy cycles; returns at the done cycle.
  task automatic runOp(input logic [2:0] op, input logic [7:0] a, input logic [7:0] x,
                       input logic [15:0] ax, input logic [15:0] bc, output int cycles);
    @(negedge clk);
    opSel = op; aIn = a; xIn = x; axIn = ax; bcIn = bc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (busy && cycles < 10) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic loadAcc(input logic [31:0] v);
    @(negedge clk);
    accLoad = 1'b1; accLoadVal = v;
    @(negedge clk);
    accLoad = 1'b0;
    mAcc = v;
  endtask

  task automatic checkFlags(input string req);
    chk(req, "acc", accOut, mAcc);
    chk(req, "cy", 32'(cyOut), 32'(mCy));
    chk(req, "ac", 32'(acOut), 32'(mAc));
  endtask

  task automatic testReset();
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "strobes", {30'd0, axWr, bcWr}, 0);
    chk("R1", "ax/bc", {axOut, bcOut}, 0);
    checkFlags("R1");
  endtask

  task automatic testMul8(input logic [7:0] a, input logic [7:0] x);
    int n;
    runOp(3'd0, a, x, 16'h1234, 16'h5678, n);
    chk("R2", "latency", 32'(n), 1);
    chk("R2", "done", 32'(done), 1);
    chk("R2", "axWr", 32'(axWr), 1);
    chk("R2", "bcWr", 32'(bcWr), 0);
    chk("R2", "product", 32'(axOut), 32'(a) * 32'(x));
    checkFlags("R7");
  endtask

  task automatic testMul16(input logic sgn, input logic [15:0] ax, input logic [15:0] bc);
    int n;
    logic [31:0] p;
    string r;
    r = sgn ? "R4" : "R3";
    if (sgn) p = 32'($signed(ax) * $signed(bc));
    else     p = 32'(ax) * 32'(bc);
    runOp(sgn ? 3'd2 : 3'd1, 8'h00, 8'h00, ax, bc, n);
    chk(r, "latency", 32'(n), 2);
    chk(r, "strobes", {30'd0, axWr, bcWr}, 3);
    chk(r, "high to bc", 32'(bcOut), 32'(p[31:16]));
    chk(r, "low to ax", 32'(axOut), 32'(p[15:0]));
    checkFlags("R7");
  endtask

  task automatic testMac(input logic sgn, input logic [15:0] ax, input logic [15:0] bc);
    int n;
    logic [31:0] p, nw;
    string r;
    r = sgn ? "R5" : "R6";
    if (sgn) p = 32'($signed(ax) * $signed(bc));
    else     p = 32'(ax) * 32'(bc);
    nw = mAcc + p;
    if (sgn) begin mCy = nw[31] ^ mAcc[31]; mAc = nw[31]; end
    else     begin mCy = (nw < mAcc);       mAc = 1'b0;   end
    mAcc = nw;
    runOp(sgn ? 3'd4 : 3'd3, 8'h00, 8'h00, ax, bc, n);
    chk(r, "latency", 32'(n), 3);
    chk("R7", "done", 32'(done), 1);
    chk("R7", "no write-back", {30'd0, axWr, bcWr}, 0);
    checkFlags(r);
  endtask

  task automatic testStartWhileBusy();
    logic [15:0] axBefore;
    axBefore = axOut;
    @(negedge clk);
    opSel = 3'd3; axIn = 16'd2; bcIn = 16'd5; start = 1'b1;
    @(negedge clk);
    opSel = 3'd0; aIn = 8'd3; xIn = 8'd3;           // start held high while busy
    accLoad = 1'b1; accLoadVal = 32'hDEAD_BEEF;     // load while busy
    @(negedge clk);
    start = 1'b0; accLoad = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mCy = (mAcc + 32'd10) < mAcc; mAc = 1'b0; mAcc = mAcc + 32'd10;
    chk("R8", "busy low after 3", 32'(busy), 0);
    chk("R9", "load ignored while busy", accOut, mAcc);
    @(negedge clk);
    chk("R8", "no second op", 32'(busy), 0);
    chk("R8", "ax untouched", 32'(axOut), 32'(axBefore));
  endtask

  task automatic testLoadBlocksStart();
    @(negedge clk);
    opSel = 3'd1; axIn = 16'd4; bcIn = 16'd4; start = 1'b1;
    accLoad = 1'b1; accLoadVal = 32'h0000_0042;
    @(negedge clk);
    start = 1'b0; accLoad = 1'b0;
    mAcc = 32'h42;
    chk("R9", "start ignored with load", 32'(busy), 0);
    chk("R9", "acc loaded", accOut, mAcc);
  endtask

  task automatic testBadOp(input logic [2:0] op);
    @(negedge clk);
    opSel = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "busy", 32'(busy), 0);
    @(negedge clk);
    chk("R10", "no done", {29'd0, done, axWr, bcWr}, 0);
    checkFlags("R10");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMul8(8'hFF, 8'hFF);
    testMul8(8'd7, 8'd9);
    testMul16(1'b0, 16'hFFFF, 16'hFFFF);
    testMul16(1'b0, 16'h1234, 16'h00FF);
    testMul16(1'b1, 16'hFFFF, 16'hFFFF);
    testMul16(1'b1, 16'h8000, 16'h8000);
    testMul16(1'b1, 16'hFFFE, 16'h0003);
    loadAcc(32'd0);
    testMac(1'b1, 16'd2, 16'd3);
    loadAcc(32'h7FFF_FFFF);
    testMac(1'b1, 16'd1, 16'd1);
    testMac(1'b1, 16'hFFFF, 16'd1);
    testMac(1'b1, 16'hFFF0, 16'h0100);
    loadAcc(32'hFFFF_FFF0);
    testMac(1'b0, 16'h0010, 16'h0001);
    testMac(1'b0, 16'h0001, 16'h0001);
    loadAcc(32'hFFFF_0000);
    testMac(1'b0, 16'hFFFF, 16'hFFFF);
    testMul16(1'b0, 16'h0002, 16'h0003);
    testMul8(8'd1, 8'd1);
    testStartWhileBusy();
    testLoadBlocksStart();
    testBadOp(3'd5);
    testBadOp(3'd7);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule